// File: doc/BRIEF.md
# Parallel NOR Flash Program Sequencer

This block is a host-side controller that places one byte or word into an asynchronous parallel NOR flash. A caller presents an address and a data value on a request port. The block then runs the full programming conversation on the flash bus by itself. It writes the program-setup command and then the data to the target location. It reads the status register until the device reports that its internal write engine is ready. It decodes the error flags and, if one of them is set, clears them. It always ends by returning the device to read-array mode. The outcome is reported as a 3-bit code together with a one-cycle completion strobe.

Bus timing is given in clock cycles by parameters: the data setup time before the write strobe, the width of the write strobe and the delay from output-enable to data sampling. Successive status reads are refreshed by raising output-enable and lowering it again, so no read-status command is issued. A poll limit turns a device that never becomes ready into a timeout result.

The controller state machine has eight states. The arcs are:
- IDLE to SETUP_CMD when a request arrives.
- SETUP_CMD to DATA_WR when the 40h write completes.
- DATA_WR to POLL when the data write completes.
- POLL to CHECK on a ready status.
- POLL to POLL on a busy status below the limit.
- POLL to CLEAR when the limit is reached.
- CHECK to ARRAY on a clean status.
- CHECK to CLEAR on an error.
- CLEAR to ARRAY after the 50h write.
- ARRAY to DONE after the FFh write.
- DONE to IDLE after one cycle.

The bus-cycle engine beneath it has six phases. IDLE leads to either SETUP, PULSE and HOLD for a write, or RDWAIT and RECOV for a read. Both paths return to IDLE.

Top module: `nor_prog_seq`

## Requirements
- R1: After reset, and at once while reset is asserted, flash_ce_n, flash_we_n and flash_oe_n are all high and done is low.
- R2: req_ack pulses for exactly one cycle when a request is taken in IDLE. A request held high for the whole operation is acknowledged only once.
- R3: The first flash write of an operation carries 40h on the data lines and the second carries req_data. Both go to req_addr.
- R4: Every write keeps flash_we_n low for exactly WE_CYC cycles. The data lines hold the same driven value from the falling edge of flash_we_n through its rising edge.
- R5: flash_we_n and flash_oe_n are never low together. The controller releases the data lines whenever flash_oe_n is low. Either strobe is low only while flash_ce_n is low.
- R6: After the data write, the status register is read repeatedly until status bit 7 is 1. flash_oe_n returns high between successive reads, so for B busy reads followed by one ready read there are B+1 falling edges of flash_oe_n.
- R7: A ready status is decoded by priority. Bit 3 set gives code 1 (supply-range error). Otherwise bit 1 set gives code 2 (locked block). Otherwise bit 4 set gives code 3 (program failure). Otherwise the code is 0 (success). Bits 0, 2, 5 and 6 have no effect.
- R8: On any nonzero code, a write of 50h is issued after the data write and before the final write. With code 0, no 50h write appears.
- R9: Every operation ends with a write of FFh as the last flash write before done.
- R10: If MAX_POLLS consecutive status reads show bit 7 as 0, the result is code 4 (timeout), followed by the 50h and FFh writes. MAX_POLLS-1 busy reads followed by a ready read still complete normally.
- R11: done is high for one cycle with result valid in that cycle. result then holds its value until the next operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request to program one location |
| req_addr | input | ADDR_W | Target location |
| req_data | input | DATA_W | Value to program |
| req_ack | output | 1 | One-cycle pulse when the request is taken |
| done | output | 1 | One-cycle completion strobe |
| result | output | 3 | 0 ok, 1 supply-range error, 2 locked, 3 program failure, 4 timeout |
| flash_addr | output | ADDR_W | Flash address lines |
| flash_dq | inout | DATA_W | Flash data lines, status in bits 7:0 |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write strobe, active low |
| flash_oe_n | output | 1 | Output enable, active low |

## Verification
The hardest behaviour to reach from the ports depends on what the flash reports and for how long it stays busy. This covers the priority between error flags that are set together, the exact boundary where the poll limit turns into a timeout, and a reset that arrives in the middle of polling. The bench stands in for the flash with a behavioural model that logs every write at the rising edge of the write strobe. The model counts output-enable falls as reads and returns a busy status for a programmed number of reads, then a ready status carrying chosen error bits. A table of busy counts and error patterns then drives each of these cases, including multi-flag patterns, a busy count one below the limit, and a device that never becomes ready.

// File: rtl/nps_pkg.sv
package nps_pkg;

    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_VPP     = 3'd1,
        RES_LOCKED  = 3'd2,
        RES_PROG    = 3'd3,
        RES_TIMEOUT = 3'd4
    } nps_result_e;

    typedef enum logic [2:0] {
        B_IDLE,
        B_SETUP,
        B_PULSE,
        B_HOLD,
        B_RDWAIT,
        B_RECOV
    } nps_bus_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP_CMD,
        S_DATA_WR,
        S_POLL,
        S_CHECK,
        S_CLEAR,
        S_ARRAY,
        S_DONE
    } nps_state_e;

    localparam logic [7:0] CMD_PROGRAM    = 8'h40;
    localparam logic [7:0] CMD_CLEAR_STAT = 8'h50;
    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;

    localparam int SR_READY_BIT = 7;
    localparam int SR_PROG_BIT  = 4;
    localparam int SR_VPP_BIT   = 3;
    localparam int SR_LOCK_BIT  = 1;

endpackage

// File: rtl/nps_bus_cycle.sv
module nps_bus_cycle
    import nps_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int SETUP_CYC = 2,
    parameter int WE_CYC    = 2,
    parameter int OE_CYC    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_write,
    input  logic [DATA_W-1:0] wdata,
    input  logic [7:0]        dq_in,
    output logic              ready,
    output logic              done,
    output logic [7:0]        rdata,
    output logic              ce_n,
    output logic              we_n,
    output logic              oe_n,
    output logic              dq_oe,
    output logic [DATA_W-1:0] dq_out
);

    localparam int MAX_AB = (SETUP_CYC > WE_CYC) ? SETUP_CYC : WE_CYC;
    localparam int MAXC   = (MAX_AB > OE_CYC) ? MAX_AB : OE_CYC;
    localparam int CW     = $clog2(MAXC + 1);

    nps_bus_e          phase, phase_n;
    logic [CW-1:0]     cnt;
    logic [DATA_W-1:0] wdata_q;
    logic [7:0]        rdata_q;
    logic              done_q;

    // phase register, counter and captures
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase   <= B_IDLE;
            cnt     <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            phase  <= phase_n;
            done_q <= (phase == B_HOLD) || (phase == B_RECOV);
            if (phase != phase_n) begin
                unique case (phase_n)
                    B_SETUP:  cnt <= CW'(SETUP_CYC - 1);
                    B_PULSE:  cnt <= CW'(WE_CYC - 1);
                    B_RDWAIT: cnt <= CW'(OE_CYC - 1);
                    default:  cnt <= '0;
                endcase
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
            if (phase == B_IDLE && start) begin
                wdata_q <= wdata;
            end
            if (phase == B_RDWAIT && cnt == '0) begin
                rdata_q <= dq_in;
            end
        end
    end

    // next phase
    always_comb begin
        phase_n = phase;
        unique case (phase)
            B_IDLE:   if (start) phase_n = is_write ? B_SETUP : B_RDWAIT;
            B_SETUP:  if (cnt == '0) phase_n = B_PULSE;
            B_PULSE:  if (cnt == '0) phase_n = B_HOLD;
            B_HOLD:   phase_n = B_IDLE;
            B_RDWAIT: if (cnt == '0) phase_n = B_RECOV;
            B_RECOV:  phase_n = B_IDLE;
            default:  phase_n = B_IDLE;
        endcase
    end

    // bus outputs
    always_comb begin
        ce_n   = (phase == B_IDLE);
        we_n   = (phase != B_PULSE);
        oe_n   = (phase != B_RDWAIT);
        dq_oe  = (phase == B_SETUP) || (phase == B_PULSE) || (phase == B_HOLD);
        dq_out = wdata_q;
        ready  = (phase == B_IDLE) && !done_q;
        done   = done_q;
        rdata  = rdata_q;
    end

endmodule

// File: rtl/nps_poll_timer.sv
module nps_poll_timer #(
    parameter int MAX_POLLS = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic last
);

    localparam int CW = $clog2(MAX_POLLS + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // the read now completing is the MAX_POLLS-th busy one
    assign last = (cnt == CW'(MAX_POLLS - 1));

endmodule

// File: rtl/nps_status_decode.sv
module nps_status_decode
    import nps_pkg::*;
(
    input  logic [7:0]  sr,
    output logic        ready,
    output nps_result_e code
);

    logic unused_sr;
    assign unused_sr = ^{sr[6:5], sr[2], sr[0]};

    always_comb begin
        ready = sr[SR_READY_BIT];
        if (sr[SR_VPP_BIT]) begin
            code = RES_VPP;
        end else if (sr[SR_LOCK_BIT]) begin
            code = RES_LOCKED;
        end else if (sr[SR_PROG_BIT]) begin
            code = RES_PROG;
        end else begin
            code = RES_OK;
        end
    end

endmodule

// File: rtl/nor_prog_seq.sv
module nor_prog_seq
    import nps_pkg::*;
#(
    parameter int ADDR_W    = 23,
    parameter int DATA_W    = 16,
    parameter int SETUP_CYC = 2,
    parameter int WE_CYC    = 2,
    parameter int OE_CYC    = 3,
    parameter int MAX_POLLS = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ack,
    output logic              done,
    output logic [2:0]        result,
    output logic [ADDR_W-1:0] flash_addr,
    inout  wire  [DATA_W-1:0] flash_dq,
    output logic              flash_ce_n,
    output logic              flash_we_n,
    output logic              flash_oe_n
);

    localparam int PAD_W = DATA_W - 8;

    nps_state_e        state, state_n;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    nps_result_e       res_q;

    logic              bus_start;
    logic              bus_write;
    logic [DATA_W-1:0] bus_wdata;
    logic              bus_ready;
    logic              bus_done;
    logic [7:0]        bus_rdata;
    logic              dq_oe;
    logic [DATA_W-1:0] dq_out;

    logic              tmr_clear;
    logic              tmr_tick;
    logic              tmr_last;

    logic              dec_ready;
    nps_result_e       dec_code;

    nps_bus_cycle #(
        .DATA_W    (DATA_W),
        .SETUP_CYC (SETUP_CYC),
        .WE_CYC    (WE_CYC),
        .OE_CYC    (OE_CYC)
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (bus_start),
        .is_write (bus_write),
        .wdata    (bus_wdata),
        .dq_in    (flash_dq[7:0]),
        .ready    (bus_ready),
        .done     (bus_done),
        .rdata    (bus_rdata),
        .ce_n     (flash_ce_n),
        .we_n     (flash_we_n),
        .oe_n     (flash_oe_n),
        .dq_oe    (dq_oe),
        .dq_out   (dq_out)
    );

    nps_poll_timer #(
        .MAX_POLLS (MAX_POLLS)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_clear),
        .tick  (tmr_tick),
        .last  (tmr_last)
    );

    nps_status_decode u_decode (
        .sr    (bus_rdata),
        .ready (dec_ready),
        .code  (dec_code)
    );

    assign flash_dq   = dq_oe ? dq_out : {DATA_W{1'bz}};
    assign flash_addr = addr_q;

    // state register and captured request / result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            addr_q <= '0;
            data_q <= '0;
            res_q  <= RES_OK;
        end else begin
            state <= state_n;
            if (state == S_IDLE && req_valid) begin
                addr_q <= req_addr;
                data_q <= req_data;
            end
            if (state == S_CHECK) begin
                res_q <= dec_code;
            end else if (state == S_POLL && bus_done && !dec_ready && tmr_last) begin
                res_q <= RES_TIMEOUT;
            end
        end
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:      if (req_valid) state_n = S_SETUP_CMD;
            S_SETUP_CMD: if (bus_done) state_n = S_DATA_WR;
            S_DATA_WR:   if (bus_done) state_n = S_POLL;
            S_POLL: begin
                if (bus_done) begin
                    if (dec_ready)     state_n = S_CHECK;
                    else if (tmr_last) state_n = S_CLEAR;
                end
            end
            S_CHECK:     state_n = (dec_code == RES_OK) ? S_ARRAY : S_CLEAR;
            S_CLEAR:     if (bus_done) state_n = S_ARRAY;
            S_ARRAY:     if (bus_done) state_n = S_DONE;
            S_DONE:      state_n = S_IDLE;
            default:     state_n = S_IDLE;
        endcase
    end

    // outputs and bus-engine controls
    always_comb begin
        req_ack   = (state == S_IDLE) && req_valid;
        done      = (state == S_DONE);
        result    = res_q;
        bus_write = (state != S_POLL);
        bus_start = bus_ready && ((state == S_SETUP_CMD) || (state == S_DATA_WR) ||
                                  (state == S_POLL) || (state == S_CLEAR) ||
                                  (state == S_ARRAY));
        tmr_clear = (state == S_DATA_WR);
        tmr_tick  = (state == S_POLL) && bus_done && !dec_ready;
        unique case (state)
            S_SETUP_CMD: bus_wdata = {{PAD_W{1'b0}}, CMD_PROGRAM};
            S_DATA_WR:   bus_wdata = data_q;
            S_CLEAR:     bus_wdata = {{PAD_W{1'b0}}, CMD_CLEAR_STAT};
            S_ARRAY:     bus_wdata = {{PAD_W{1'b0}}, CMD_READ_ARRAY};
            default:     bus_wdata = '0;
        endcase
    end

endmodule

// File: rtl/nps_checker.sv
module nps_checker #(
    parameter int WE_CYC = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       flash_ce_n,
    input logic       flash_we_n,
    input logic       flash_oe_n,
    input logic       dq_oe,
    input logic       req_ack,
    input logic       done,
    input logic [2:0] result
);

    int we_lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_lo_cnt <= 0;
        end else begin
            we_lo_cnt <= flash_we_n ? 0 : we_lo_cnt + 1;
        end
    end

    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!flash_we_n && !flash_oe_n));

    assert_dq_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_oe_n |-> !dq_oe);

    assert_ce_with_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_we_n || !flash_oe_n) |-> !flash_ce_n);

    assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_we_n) |-> (we_lo_cnt == WE_CYC));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    assert_result_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result <= 3'd4));

endmodule

bind nor_prog_seq nps_checker #(.WE_CYC(WE_CYC)) u_nps_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .flash_ce_n (flash_ce_n),
    .flash_we_n (flash_we_n),
    .flash_oe_n (flash_oe_n),
    .dq_oe      (dq_oe),
    .req_ack    (req_ack),
    .done       (done),
    .result     (result)
);

// File: tb/nor_prog_seq_bench.sv
module nor_prog_seq_bench;

    localparam int AW   = 23;
    localparam int DW   = 16;
    localparam int SETC = 2;
    localparam int WEC  = 3;
    localparam int OEC  = 2;
    localparam int MAXP = 6;
    localparam int NVEC = 8;

    localparam logic [7:0] V_ERR  [0:NVEC-1] = '{8'h00, 8'h00, 8'h08, 8'h02, 8'h10, 8'h1A, 8'h12, 8'h65};
    localparam int         V_BUSY [0:NVEC-1] = '{0, 3, 1, 2, 0, 0, 0, 5};
    localparam logic [2:0] V_EXP  [0:NVEC-1] = '{3'd0, 3'd0, 3'd1, 3'd2, 3'd3, 3'd1, 3'd2, 3'd0};

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_data;
    logic          req_ack;
    logic          done;
    logic [2:0]    result;
    logic [AW-1:0] flash_addr;
    wire  [DW-1:0] flash_dq;
    logic          flash_ce_n;
    logic          flash_we_n;
    logic          flash_oe_n;

    int checks = 0;
    int errors = 0;

    nor_prog_seq #(
        .ADDR_W    (AW),
        .DATA_W    (DW),
        .SETUP_CYC (SETC),
        .WE_CYC    (WEC),
        .OE_CYC    (OEC),
        .MAX_POLLS (MAXP)
    ) u_nor_prog_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_data   (req_data),
        .req_ack    (req_ack),
        .done       (done),
        .result     (result),
        .flash_addr (flash_addr),
        .flash_dq   (flash_dq),
        .flash_ce_n (flash_ce_n),
        .flash_we_n (flash_we_n),
        .flash_oe_n (flash_oe_n)
    );

    // ---------------- flash model ----------------
    int            busy_reads = 0;
    logic [7:0]    err_bits   = 8'h00;
    int            reads_seen = 0;
    int            wcount     = 0;
    int            we_bad     = 0;
    int            overlap    = 0;
    time           we_fall_t  = 0;
    logic [DW-1:0] dq_at_fall;
    logic [DW-1:0] wl_data [0:7];
    logic [AW-1:0] wl_addr [0:7];
    logic [7:0]    model_sr;

    always_comb model_sr = (reads_seen <= busy_reads) ? 8'h00 : (8'h80 | err_bits);

    assign flash_dq = (!flash_oe_n && !flash_ce_n) ? {{(DW-8){1'b0}}, model_sr} : {DW{1'bz}};

    always @(negedge flash_oe_n) reads_seen++;

    always @(negedge flash_we_n) begin
        we_fall_t  = $time;
        dq_at_fall = flash_dq;
    end

    always @(posedge flash_we_n) begin
        if (($time - we_fall_t) != WEC * 20) we_bad++;
        if (flash_dq !== dq_at_fall) we_bad++;
        if (wcount < 8) begin
            wl_addr[wcount] = flash_addr;
            wl_data[wcount] = flash_dq;
        end
        wcount++;
    end

    always @(negedge clk) begin
        if (rst_n && !flash_we_n && !flash_oe_n) overlap++;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [7:0] err,
                          input int busy, input logic [2:0] exp_res, input bit hold);
        int acks;
        int dones;
        bit got;
        logic [2:0] res;
        int exp_reads;
        int exp_w;
        acks = 0; dones = 0; got = 0; res = 3'd7;
        busy_reads = busy; err_bits = err;
        reads_seen = 0; wcount = 0; we_bad = 0;
        @(negedge clk);
        req_addr = a; req_data = d; req_valid = 1'b1;
        for (int cyc = 0; cyc < 3000 && !got; cyc++) begin
            #1;
            if (req_ack) acks++;
            if (done) begin dones++; res = result; got = 1; end
            @(negedge clk);
            if (!hold && acks > 0) req_valid = 1'b0;
            if (hold && got) req_valid = 1'b0;
        end
        req_valid = 1'b0;
        #1;
        chk(got, "R11 done seen", 32'(got), 32'd1);
        chk(!done, "R11 done one cycle", 32'(done), 32'd0);
        chk(acks == 1, "R2 ack count", 32'(acks), 32'd1);
        if (exp_res == 3'd4) chk(res == exp_res, "R10 timeout code", 32'(res), 32'(exp_res));
        else                 chk(res == exp_res, "R7 result code", 32'(res), 32'(exp_res));
        exp_reads = (busy < MAXP) ? busy + 1 : MAXP;
        chk(reads_seen == exp_reads, "R6 status reads", 32'(reads_seen), 32'(exp_reads));
        exp_w = (exp_res != 3'd0) ? 4 : 3;
        chk(wcount == exp_w, "R8 write count", 32'(wcount), 32'(exp_w));
        chk(wl_data[0] == 16'h0040 && wl_addr[0] == a, "R3 setup write", 32'(wl_data[0]), 32'h40);
        chk(wl_data[1] == d && wl_addr[1] == a, "R3 data write", 32'(wl_data[1]), 32'(d));
        if (exp_res != 3'd0)
            chk(wl_data[2] == 16'h0050, "R8 clear-status write", 32'(wl_data[2]), 32'h50);
        chk(wl_data[exp_w-1] == 16'h00FF, "R9 final read-array write", 32'(wl_data[exp_w-1]), 32'hFF);
        chk(we_bad == 0, "R4 strobe width and data stability", 32'(we_bad), 32'd0);
        repeat (3) @(negedge clk);
        #1;
        chk(result == exp_res, "R11 result holds", 32'(result), 32'(exp_res));
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual expired expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_data = '0;
        repeat (4) @(negedge clk);
        #1;
        chk(flash_ce_n && flash_we_n && flash_oe_n, "R1 strobes high in reset",
            32'({flash_ce_n, flash_we_n, flash_oe_n}), 32'h7);
        chk(!done, "R1 done low in reset", 32'(done), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk(flash_ce_n && flash_we_n && flash_oe_n, "R1 strobes high after reset",
            32'({flash_ce_n, flash_we_n, flash_oe_n}), 32'h7);
        chk(result == 3'd0, "R1 result after reset", 32'(result), 32'd0);

        // table-driven operations (R3, R6, R7, R8, R9, R10 boundary in last row)
        for (int i = 0; i < NVEC; i++) begin
            run_op(AW'(23'h10_0000 + i * 23'h1234), DW'(16'hA5C3 ^ (i * 16'h1111)),
                   V_ERR[i], V_BUSY[i], V_EXP[i], 1'b0);
        end

        // R2: request held high across the whole operation
        run_op(23'h00_0ABC, 16'h1357, 8'h00, 2, 3'd0, 1'b1);

        // R10: device never ready
        run_op(23'h7F_FFF0, 16'hBEEF, 8'h00, 1000, 3'd4, 1'b0);

        // R1: reset in the middle of polling
        busy_reads = 1000; err_bits = 8'h00; reads_seen = 0;
        @(negedge clk);
        req_addr = 23'h12_3456; req_data = 16'h0F0F; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(flash_ce_n && flash_we_n && flash_oe_n, "R1 strobes high on mid-op reset",
            32'({flash_ce_n, flash_we_n, flash_oe_n}), 32'h7);
        chk(!done, "R1 done low on mid-op reset", 32'(done), 32'd0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        run_op(23'h00_0001, 16'h8001, 8'h00, 0, 3'd0, 1'b0);

        chk(overlap == 0, "R5 strobe overlap", 32'(overlap), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule